// File: doc/BRIEF.md
# Two-Level I/O Address Translation Walker

This block turns a 32-bit device-side virtual address into a physical address. It does this by reading descriptors from a two-level table held in ordinary memory. A requester hands over one address on a valid/ready handshake. At that moment the block also captures the first-level table base and the table length, given as a base-2 logarithm of the entry count, from the control inputs. The block then issues one or two single-word reads on a request/valid memory read port whose latency may vary. It returns either a physical address or a fault flag on a valid/ready response port.

Three mapping granules are supported:

- A first-level descriptor can map a whole 1 MiB region directly.
- A first-level descriptor can instead point to a 256-entry second-level table, whose entries map 4 KiB pages.
- Second-level entries can also map 64 KiB pages. Software writes the same 64 KiB descriptor into sixteen aligned neighbouring entries, so any of those sixteen yields the same translation.

The block handles one walk at a time. It keeps no results between walks.

Top module: `iova_walker`

## Requirements
- R1: `req_ready` is high only while no walk is in progress, and `req_ready` and `rsp_valid` are never high together. The address, base and length are captured when a request is accepted, so changes on `cfg_base` or `cfg_l1_log2` after acceptance have no effect on that walk.
- R2: The first-level read goes to `cfg_base + VA[31:20]*4`.
- R3: If `VA[31:20] >= 2**cfg_l1_log2` (supported lengths 5 to 11), the walk issues no memory read and presents a fault response on the cycle after acceptance. An index of `2**cfg_l1_log2 - 1` is in range.
- R4: A first-level descriptor with bits [1:0] = 2'b10 gives the physical address `{desc[31:20], VA[19:0]}`.
- R5: A first-level descriptor with bits [1:0] = 2'b01 starts a second-level read at `{desc[31:10], 10'b0} + VA[19:12]*4`.
- R6: A second-level descriptor with bits [1:0] = 2'b10 gives the physical address `{desc[31:12], VA[11:0]}`.
- R7: A second-level descriptor with bits [1:0] = 2'b01 gives the physical address `{desc[31:16], VA[15:0]}`. Any of the sixteen aligned replicated entries gives the same result.
- R8: A descriptor with bits [1:0] of 2'b00, at either level, gives a fault. So does 2'b11 at either level. A fault response carries `rsp_pa` = 0.
- R9: `mem_req` stays high with a stable `mem_addr` until `mem_rvalid` is seen. At most one read is outstanding.
- R10: A response stays valid and unchanged until `rsp_ready` is high at a clock edge. The block is ready for a new request in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_va | input | 32 | Virtual address to translate |
| cfg_base | input | 32 | First-level table base address |
| cfg_l1_log2 | input | 4 | Base-2 log of the first-level entry count |
| mem_req | output | 1 | Descriptor read request, held until data returns |
| mem_addr | output | 32 | Byte address of the descriptor word |
| mem_rvalid | input | 1 | Read data valid; completes the pending read |
| mem_rdata | input | 32 | Descriptor word read |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_pa | output | 32 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Address unmapped or out of range |

## Verification
The captured second-level base is the only record of the first-level descriptor once that descriptor has been read. If it is corrupted, the wrong address appears on `mem_addr` in the very cycle the second read is requested, before any response. The bench compares every read address against its model on every clock for exactly that reason.

A wrong walk state shows up at the ports in one of two ways. It can produce an unexpected `mem_req` on a range fault, which is caught the same cycle. It can also produce a `req_ready` that rises during a walk, which is caught at the next falling edge. A wrong offset-field split is only visible in `rsp_pa` at response time, so each granule is exercised with distinct low-address patterns.

// File: rtl/iowalk_pkg.sv
package iowalk_pkg;

    localparam int VA_W        = 32;
    localparam int L1_IDX_W    = 12;
    localparam int L2_IDX_W    = 8;
    localparam int SEC_OFF_W   = VA_W - L1_IDX_W;
    localparam int SPG_OFF_W   = SEC_OFF_W - L2_IDX_W;
    localparam int LPG_OFF_W   = SPG_OFF_W + 4;
    localparam int L2_ALIGN_W  = L2_IDX_W + 2;
    localparam int WORD_LOG2   = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_L1   = 2'd1,
        ST_L2   = 2'd2,
        ST_RSP  = 2'd3
    } walk_st_e;

    typedef enum logic [1:0] {
        DK_FAULT = 2'd0,
        DK_NEXT  = 2'd1,
        DK_LEAF  = 2'd2
    } desc_kind_e;

    typedef struct packed {
        walk_st_e          st;
        logic [VA_W-1:0]   va;
        logic [VA_W-1:0]   l1_base;
        logic [VA_W-1:0]   l2_base;
        logic [VA_W-1:0]   pa;
        logic              fault;
    } walk_s;

endpackage

// File: rtl/iowalk_addr_gen.sv
module iowalk_addr_gen
    import iowalk_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [VA_W-1:0]  base,
    input  logic [IDX_W-1:0] idx,
    output logic [VA_W-1:0]  addr
);
    localparam int PAD_W = VA_W - IDX_W;

    always_comb begin
        addr = base + ({{PAD_W{1'b0}}, idx} << WORD_LOG2);
    end
endmodule

// File: rtl/iowalk_range.sv
module iowalk_range
    import iowalk_pkg::*;
#(
    parameter int LOG2_W = 4
) (
    input  logic [L1_IDX_W-1:0] idx,
    input  logic [LOG2_W-1:0]   len_log2,
    output logic                in_range
);
    always_comb begin
        in_range = ((idx >> len_log2) == '0);
    end
endmodule

// File: rtl/iowalk_desc_dec.sv
module iowalk_desc_dec
    import iowalk_pkg::*;
(
    input  logic              second,
    input  logic [VA_W-1:0]   desc,
    input  logic [VA_W-1:0]   va,
    output desc_kind_e        kind,
    output logic [VA_W-1:0]   leaf_pa,
    output logic [VA_W-1:0]   next_base
);
    logic unused_desc_bits;
    assign unused_desc_bits = ^desc[L2_ALIGN_W-1:2];

    always_comb begin
        kind      = DK_FAULT;
        leaf_pa   = '0;
        next_base = {desc[VA_W-1:L2_ALIGN_W], {L2_ALIGN_W{1'b0}}};
        if (!second) begin
            unique case (desc[1:0])
                2'b10: begin
                    kind    = DK_LEAF;
                    leaf_pa = {desc[VA_W-1:SEC_OFF_W], va[SEC_OFF_W-1:0]};
                end
                2'b01: kind = DK_NEXT;
                default: kind = DK_FAULT;
            endcase
        end else begin
            unique case (desc[1:0])
                2'b10: begin
                    kind    = DK_LEAF;
                    leaf_pa = {desc[VA_W-1:SPG_OFF_W], va[SPG_OFF_W-1:0]};
                end
                2'b01: begin
                    kind    = DK_LEAF;
                    leaf_pa = {desc[VA_W-1:LPG_OFF_W], va[LPG_OFF_W-1:0]};
                end
                default: kind = DK_FAULT;
            endcase
        end
    end
endmodule

// File: rtl/iova_walker.sv
module iova_walker
    import iowalk_pkg::*;
#(
    parameter int LOG2_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_va,
    input  logic [31:0]       cfg_base,
    input  logic [LOG2_W-1:0] cfg_l1_log2,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [31:0]       rsp_pa,
    output logic              rsp_fault
);
    walk_s q, d;

    logic              in_range;
    logic [VA_W-1:0]   l1_addr, l2_addr;
    desc_kind_e        kind;
    logic [VA_W-1:0]   leaf_pa, next_base;

    iowalk_range #(.LOG2_W(LOG2_W)) u_range (
        .idx      (req_va[VA_W-1:SEC_OFF_W]),
        .len_log2 (cfg_l1_log2),
        .in_range (in_range)
    );

    iowalk_addr_gen #(.IDX_W(L1_IDX_W)) u_l1_addr (
        .base (q.l1_base),
        .idx  (q.va[VA_W-1:SEC_OFF_W]),
        .addr (l1_addr)
    );

    iowalk_addr_gen #(.IDX_W(L2_IDX_W)) u_l2_addr (
        .base (q.l2_base),
        .idx  (q.va[SEC_OFF_W-1:SPG_OFF_W]),
        .addr (l2_addr)
    );

    iowalk_desc_dec u_dec (
        .second    (q.st == ST_L2),
        .desc      (mem_rdata),
        .va        (q.va),
        .kind      (kind),
        .leaf_pa   (leaf_pa),
        .next_base (next_base)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va      = req_va;
                    d.l1_base = cfg_base;
                    d.pa      = '0;
                    d.fault   = 1'b0;
                    if (in_range) begin
                        d.st = ST_L1;
                    end else begin
                        d.st    = ST_RSP;
                        d.fault = 1'b1;
                    end
                end
            end
            ST_L1, ST_L2: begin
                if (mem_rvalid) begin
                    if (kind == DK_LEAF) begin
                        d.st = ST_RSP;
                        d.pa = leaf_pa;
                    end else if (kind == DK_NEXT) begin
                        d.st      = ST_L2;
                        d.l2_base = next_base;
                    end else begin
                        d.st    = ST_RSP;
                        d.pa    = '0;
                        d.fault = 1'b1;
                    end
                end
            end
            ST_RSP: begin
                if (rsp_ready) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign mem_req   = (q.st == ST_L1) || (q.st == ST_L2);
    assign mem_addr  = (q.st == ST_L2) ? l2_addr : l1_addr;
    assign rsp_valid = (q.st == ST_RSP);
    assign rsp_pa    = q.pa;
    assign rsp_fault = q.fault;
endmodule

// File: rtl/iova_walker_chk.sv
module iova_walker_chk #(
    parameter int LOG2_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [31:0]       req_va,
    input logic [LOG2_W-1:0] cfg_l1_log2,
    input logic              mem_req,
    input logic [31:0]       mem_addr,
    input logic              mem_rvalid,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [31:0]       rsp_pa,
    input logic              rsp_fault
);
    // R1
    idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (rsp_valid || mem_req)));

    // R3
    range_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ((req_va[31:20] >> cfg_l1_log2) != 12'd0))
        |=> (rsp_valid && rsp_fault && !mem_req));

    // R8
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_pa == 32'd0));

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)));

    // R10
    rsp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));
endmodule

bind iova_walker iova_walker_chk #(.LOG2_W(LOG2_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_va      (req_va),
    .cfg_l1_log2 (cfg_l1_log2),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_rvalid  (mem_rvalid),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_pa      (rsp_pa),
    .rsp_fault   (rsp_fault)
);

// File: tb/iova_walker_tb_top.sv
`timescale 1ns/1ps
module iova_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [31:0] cfg_base = '0;
    logic [3:0]  cfg_l1_log2 = 4'd11;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_pa;
    logic        rsp_fault;

    always #2 clk = ~clk;

    iova_walker dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .cfg_base(cfg_base), .cfg_l1_log2(cfg_l1_log2),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_pa(rsp_pa), .rsp_fault(rsp_fault)
    );

    localparam logic [31:0] L1B  = 32'h0010_0000;
    localparam logic [31:0] L1B2 = 32'h0010_1000;
    localparam logic [31:0] L2B  = 32'h0020_0400;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] exp_addr_q [$];
    string       exp_tag_q  [$];
    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int lat    = 0;
    int seed   = 7;
    bit done   = 0;

    task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'd0;
    endfunction

    // behavioural walk model: returns expected result, queues expected reads
    task automatic ref_walk(input logic [31:0] va, input logic [31:0] base, input int lg,
                            output logic [31:0] pa, output bit flt);
        int unsigned idx1;
        logic [31:0] a1, a2, d1, d2;
        idx1 = int'(va[31:20]);
        pa = 0; flt = 1;
        if (idx1 < (1 << lg)) begin
            a1 = base + idx1 * 4;
            exp_addr_q.push_back(a1); exp_tag_q.push_back("R2");
            d1 = rd(a1);
            if (d1[1:0] == 2'b10) begin
                pa = {d1[31:20], va[19:0]}; flt = 0;
            end else if (d1[1:0] == 2'b01) begin
                a2 = {d1[31:10], 10'd0} + int'(va[19:12]) * 4;
                exp_addr_q.push_back(a2); exp_tag_q.push_back("R5");
                d2 = rd(a2);
                if (d2[1:0] == 2'b10) begin
                    pa = {d2[31:12], va[11:0]}; flt = 0;
                end else if (d2[1:0] == 2'b01) begin
                    pa = {d2[31:16], va[15:0]}; flt = 0;
                end
            end
        end
    endtask

    // memory responder with varying latency; compares read address every clock
    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            mem_rvalid = 0;
        end else if (mem_rvalid) begin
            mem_rvalid = 0;
            seed = (seed * 1103515245 + 12345) & 32'h7fff_ffff;
            lat = (seed >> 8) % 4;
        end else if (mem_req) begin
            if (exp_addr_q.size() == 0) begin
                chk("R3", 0, mem_addr, 32'd0);
            end else begin
                chk(exp_tag_q[0], mem_addr == exp_addr_q[0], mem_addr, exp_addr_q[0]);
            end
            if (lat == 0) begin
                mem_rvalid = 1;
                mem_rdata = rd(mem_addr);
                if (exp_addr_q.size() != 0) begin
                    void'(exp_addr_q.pop_front());
                    void'(exp_tag_q.pop_front());
                end
            end else begin
                lat--;
            end
        end
        if (cycles > 20000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic walk(input logic [31:0] va, input logic [31:0] base, input logic [3:0] lg,
                        input int hold, input string tag, input bit chg);
        logic [31:0] epa;
        bit eflt;
        bit oor;
        int n;
        oor = (int'(va[31:20]) >= (1 << lg));
        ref_walk(va, base, int'(lg), epa, eflt);
        @(negedge clk);
        req_va = va; cfg_base = base; cfg_l1_log2 = lg; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        if (chg) begin
            cfg_base = base ^ 32'h0000_1000;
            cfg_l1_log2 = 4'd0;
        end
        n = 0;
        while (!rsp_valid && n < 1000) begin
            chk("R1", !req_ready, {31'd0, req_ready}, 32'd0);
            @(negedge clk);
            n++;
        end
        if (oor) chk("R3", n == 0, n, 0);
        chk(tag, rsp_valid && rsp_fault == eflt && rsp_pa == epa,
            {rsp_pa[31:1], rsp_pa[0] ^ rsp_fault ^ eflt}, epa);
        chk(tag, rsp_fault == eflt, {31'd0, rsp_fault}, {31'd0, eflt});
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R10", rsp_valid && rsp_pa == epa && rsp_fault == eflt, rsp_pa, epa);
        end
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
        chk("R10", req_ready && !rsp_valid, {30'd0, req_ready, rsp_valid}, 32'd2);
        chk("R9", exp_addr_q.size() == 0, exp_addr_q.size(), 0);
        exp_addr_q.delete();
        exp_tag_q.delete();
        cfg_l1_log2 = 4'd11;
    endtask

    initial begin
        mem[L1B + 0]        = 32'h8000_0002;
        mem[L1B + 4]        = L2B | 32'h1;
        mem[L1B + 12]       = 32'h5550_0003;
        mem[L1B + 31*4]     = 32'h1F00_0002;
        mem[L1B + 2047*4]   = 32'h7FF0_0002;
        mem[L1B2 + 0]       = 32'h9000_0002;
        mem[L2B + 3*4]      = 32'h1234_5002;
        mem[L2B + 7*4]      = 32'h4444_4003;
        for (int i = 16; i < 32; i++) mem[L2B + i*4] = 32'hABCD_0001;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", req_ready && !rsp_valid && !mem_req,
            {29'd0, req_ready, rsp_valid, mem_req}, 32'd4);

        walk(32'h0001_2345, L1B, 4'd11, 0, "R4", 0);
        walk(32'h0010_3ABC, L1B, 4'd11, 2, "R6", 0);
        walk(32'h0011_0123, L1B, 4'd11, 0, "R7", 0);
        walk(32'h0011_FEDC, L1B, 4'd11, 1, "R7", 0);
        walk(32'h0010_5000, L1B, 4'd11, 0, "R8", 0);
        walk(32'h0010_7000, L1B, 4'd11, 2, "R8", 0);
        walk(32'h0020_0000, L1B, 4'd11, 0, "R8", 0);
        walk(32'h0030_0000, L1B, 4'd11, 0, "R8", 0);
        walk(32'h01F0_0ABC, L1B, 4'd5,  0, "R3", 0);
        walk(32'h0200_0000, L1B, 4'd5,  1, "R3", 0);
        walk(32'h7FF4_5678, L1B, 4'd11, 0, "R4", 0);
        walk(32'h8000_0000, L1B, 4'd11, 0, "R3", 0);
        walk(32'h0000_0042, L1B, 4'd11, 0, "R1", 1);
        walk(32'h0011_0FFF, L1B, 4'd11, 3, "R10", 1);
        walk(32'h000F_FFFF, L1B2, 4'd5, 0, "R2", 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule